// File: doc/BRIEF.md
# BF16 Widening Multiply-Accumulate Lane Array

This block takes a 128-bit vector of eight BF16 values, a second 128-bit vector of eight BF16 values, and a 128-bit accumulator of four FP32 values. It returns four FP32 results. A control input picks either the even or the odd BF16 slots of the first vector, one for each 32-bit lane. A 3-bit index picks a single BF16 element of the second vector, and that element is broadcast to all four lanes.

Each lane widens both BF16 operands to FP32 and forms their exact product. It adds the product to the accumulator word that sits in the same 32-bit position, and rounds only the final sum, using round-to-nearest-even. NaNs come out as a single default quiet NaN. Subnormal operands and subnormal results are flushed to signed zero.

An operation is issued by raising `inValid` for one cycle with the operands present. The four results appear one clock later together with `outValid`. The result register holds its value between operations.

Top module: `bfmac_array`

## Requirements
- R1: A sample taken with `inValid` high at a rising edge raises `outValid` after that edge and places its four results on `result`. A cycle with `inValid` low drops `outValid` and leaves `result` unchanged.
- R2: Lane e (0..3) takes its first multiplicand from BF16 slot 2*e + `pickOdd` of `srcA`, where slot j occupies bits [16*j+15:16*j]. `pickOdd`=0 selects the even slots and `pickOdd`=1 selects the odd slots.
- R3: The second multiplicand is BF16 slot {`idxTop`,`idxMid`,`idxLow`} of `srcB`, with `idxTop` as the most significant bit. The same value is used in all four lanes.
- R4: Lane e adds into `acc` bits [32*e+31:32*e] and writes to `result` bits [32*e+31:32*e].
- R5: For finite, non-flushed operands, each lane returns a*b + c with the product and the sum exact and one final round-to-nearest-even to FP32. The FP32 layout is sign at bit 31, exponent at bits 30:23 with bias 127, and fraction at bits 22:0. A BF16 value is the upper 16 bits of that layout.
- R6: A NaN operand (exponent all ones, nonzero fraction), infinity times zero, or the sum of infinities of opposite sign produces 32'h7FC00000.
- R7: An infinite product or an infinite accumulator gives an infinity with that operand's sign. A finite sum whose rounded exponent reaches 255 gives an infinity with the sign of the sum.
- R8: An operand with exponent field 0 counts as a zero of its own sign. A rounded result with exponent below 1 becomes a zero with the sign of the sum.
- R9: An exactly zero sum is +0, except that a -0 product added to a -0 accumulator gives -0.
- R10: While `rstN` is low, `outValid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Issue an operation this cycle |
| pickOdd | input | 1 | 0 selects the even BF16 slots of srcA, 1 selects the odd slots |
| idxTop | input | 1 | Most significant bit of the broadcast index |
| idxMid | input | 1 | Middle bit of the broadcast index |
| idxLow | input | 1 | Least significant bit of the broadcast index |
| srcA | input | 128 | Eight BF16 first multiplicands |
| srcB | input | 128 | Eight BF16 values, one of which is broadcast |
| acc | input | 128 | Four FP32 accumulator lanes |
| outValid | output | 1 | Result register was loaded on the last edge |
| result | output | 128 | Four FP32 results |

## Verification
A wrong alignment shift, a lost sticky bit or a wrong leading-one position changes a result word one clock after issue. The error shows up as a low bit that is off by one, a wrong exponent, or a wrong special-value encoding in that lane. A lane that reads the wrong slot, or an index built from its bits in the wrong order, gives wrong values as soon as the operand slots differ. Any of these faults is therefore visible at the ports on the first result after it occurs. Corrupted hold or valid state shows up in the cycle after an idle edge.

// File: rtl/bfmac_pkg.sv
package bfmac_pkg;
  localparam int LANES = 4;
  localparam int SLOTS = 2 * LANES;
  localparam int IDX_W = $clog2(SLOTS);

  typedef struct packed {
    logic             load;
    logic             pickOdd;
    logic [IDX_W-1:0] idx;
  } bfmac_strobe_t;

  localparam logic [31:0] QNAN = 32'h7FC00000;
endpackage

// File: rtl/bfmac_lane.sv
module bfmac_lane (
  input  logic [15:0] mulA,
  input  logic [15:0] mulB,
  input  logic [31:0] addC,
  output logic [31:0] sum
);
  localparam int W = 52;
  localparam int TOP = 50;
  localparam int FRAC = 48;

  logic [7:0] aE, bE, cE;
  logic aNan, bNan, cNan, aInf, bInf, cInf, aZero, bZero, pZero, cZero;
  logic pSign, cSign, pBig, bigSign, smallSign, rSign, stk, inc;
  logic [15:0] pMant;
  logic signed [11:0] pExp, cExp, bigE, diff, rExp;
  logic [W-1:0] pVec, cVec, bigV, smallV, shV, mag;
  logic [50:0] norm;
  logic [23:0] mant;
  logic [24:0] mantR;
  int k;

  always_comb begin
    aE = mulA[14:7];
    bE = mulB[14:7];
    cE = addC[30:23];
    aNan = (aE == 8'hFF) && (mulA[6:0] != 0);
    bNan = (bE == 8'hFF) && (mulB[6:0] != 0);
    cNan = (cE == 8'hFF) && (addC[22:0] != 0);
    aInf = (aE == 8'hFF) && !aNan;
    bInf = (bE == 8'hFF) && !bNan;
    cInf = (cE == 8'hFF) && !cNan;
    aZero = (aE == 8'h00);
    bZero = (bE == 8'h00);
    pZero = aZero || bZero;
    cZero = (cE == 8'h00);
    pSign = mulA[15] ^ mulB[15];
    cSign = addC[31];

    pMant = {1'b1, mulA[6:0]} * {1'b1, mulB[6:0]};
    pExp = $signed({4'b0, aE}) + $signed({4'b0, bE}) - 12'sd254;
    cExp = $signed({4'b0, cE}) - 12'sd127;
    pVec = pZero ? '0 : {2'b0, pMant, 34'b0};
    cVec = cZero ? '0 : {3'b0, 1'b1, addC[22:0], 25'b0};

    pBig = !pZero && (cZero || (pExp >= cExp));
    bigV = pBig ? pVec : cVec;
    smallV = pBig ? cVec : pVec;
    bigE = pBig ? pExp : cExp;
    bigSign = pBig ? pSign : cSign;
    smallSign = pBig ? cSign : pSign;
    diff = pBig ? (pExp - cExp) : (cExp - pExp);

    if (diff > 12'sd51) begin
      shV = '0;
      stk = |smallV;
    end else begin
      shV = smallV >> diff;
      stk = ((shV << diff) != smallV);
    end
    shV[0] = shV[0] | stk;

    if (bigSign != smallSign) begin
      if (bigV >= shV) begin
        mag = bigV - shV;
        rSign = bigSign;
      end else begin
        mag = shV - bigV;
        rSign = smallSign;
      end
    end else begin
      mag = bigV + shV;
      rSign = bigSign;
    end

    k = 0;
    for (int i = 0; i <= TOP; i++) begin
      if (mag[i]) k = i;
    end
    norm = 51'(mag << (TOP - k));
    mant = norm[50:27];
    inc = norm[26] && ((|norm[25:0]) || mant[0]);
    mantR = {1'b0, mant} + {24'b0, inc};
    rExp = bigE + 12'(k) - 12'(FRAC) + 12'sd127 + {11'b0, mantR[24]};

    if (aNan || bNan || cNan) sum = bfmac_pkg::QNAN;
    else if ((aInf || bInf) && pZero) sum = bfmac_pkg::QNAN;
    else if ((aInf || bInf) && cInf && (pSign != cSign)) sum = bfmac_pkg::QNAN;
    else if (aInf || bInf) sum = {pSign, 8'hFF, 23'b0};
    else if (cInf) sum = {cSign, 8'hFF, 23'b0};
    else if (mag == '0) sum = {pSign & cSign, 31'b0};
    else if (rExp >= 12'sd255) sum = {rSign, 8'hFF, 23'b0};
    else if (rExp <= 12'sd0) sum = {rSign, 31'b0};
    else sum = {rSign, rExp[7:0], mantR[24] ? mantR[23:1] : mantR[22:0]};
  end
endmodule

// File: rtl/bfmac_ctrl.sv
module bfmac_ctrl
  import bfmac_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          pickOdd,
  input  logic          idxTop,
  input  logic          idxMid,
  input  logic          idxLow,
  output bfmac_strobe_t strobe,
  output logic          outValid
);
  always_comb begin
    strobe.load = inValid;
    strobe.pickOdd = pickOdd;
    strobe.idx = {idxTop, idxMid, idxLow};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else outValid <= inValid;
  end
endmodule

// File: rtl/bfmac_datapath.sv
module bfmac_datapath
  import bfmac_pkg::*;
#(
  parameter int NLANES = LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  bfmac_strobe_t     strobe,
  input  logic [NLANES*32-1:0] srcA,
  input  logic [NLANES*32-1:0] srcB,
  input  logic [NLANES*32-1:0] acc,
  output logic [NLANES*32-1:0] result
);
  localparam int VW = NLANES * 32;

  logic [15:0] bcast;
  logic [VW-1:0] laneSum;

  assign bcast = srcB[16*strobe.idx +: 16];

  for (genvar e = 0; e < NLANES; e++) begin : g_lane
    logic [15:0] pickA;
    assign pickA = srcA[16*(2*e + int'(strobe.pickOdd)) +: 16];
    bfmac_lane u_lane (
      .mulA(pickA),
      .mulB(bcast),
      .addC(acc[32*e +: 32]),
      .sum (laneSum[32*e +: 32])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) result <= '0;
    else if (strobe.load) result <= laneSum;
  end
endmodule

// File: rtl/bfmac_array.sv
module bfmac_array
  import bfmac_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         pickOdd,
  input  logic         idxTop,
  input  logic         idxMid,
  input  logic         idxLow,
  input  logic [127:0] srcA,
  input  logic [127:0] srcB,
  input  logic [127:0] acc,
  output logic         outValid,
  output logic [127:0] result
);
  bfmac_strobe_t strobe;

  bfmac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pickOdd(pickOdd),
    .idxTop(idxTop), .idxMid(idxMid), .idxLow(idxLow),
    .strobe(strobe), .outValid(outValid)
  );

  bfmac_datapath #(.NLANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcA(srcA), .srcB(srcB), .acc(acc), .result(result)
  );
endmodule

// File: rtl/bfmac_chk.sv
module bfmac_chk (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         outValid,
  input logic [127:0] result
);
  function automatic logic oddNan(input logic [127:0] v);
    logic bad = 1'b0;
    for (int e = 0; e < 4; e++) begin
      if (v[32*e+23 +: 8] == 8'hFF && v[32*e +: 23] != 0 && v[32*e +: 32] != 32'h7FC00000)
        bad = 1'b1;
    end
    return bad;
  endfunction

  function automatic logic hasSub(input logic [127:0] v);
    logic bad = 1'b0;
    for (int e = 0; e < 4; e++) begin
      if (v[32*e+23 +: 8] == 8'h00 && v[32*e +: 23] != 0) bad = 1'b1;
    end
    return bad;
  endfunction

  p_issue_r1: assert property (@(posedge clk) disable iff (!rstN) inValid |=> outValid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> !outValid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> $stable(result));
  p_nan_r6: assert property (@(posedge clk) disable iff (!rstN) outValid |-> !oddNan(result));
  p_flush_r8: assert property (@(posedge clk) disable iff (!rstN) !hasSub(result));
endmodule

bind bfmac_array bfmac_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid), .result(result)
);

// File: tb/tb_bfmac_array.sv
`timescale 1ns/1ps
module tb_bfmac_array;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, pickOdd = 1'b0, idxTop = 1'b0, idxMid = 1'b0, idxLow = 1'b0;
  logic [127:0] srcA = '0, srcB = '0, acc = '0;
  logic outValid;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;
  logic [31:0] curTag = "R1";
  logic [31:0] expTag = "R10";
  logic expValid = 1'b0;
  logic [127:0] expRes = '0;

  always #2 clk = ~clk;

  bfmac_array dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pickOdd(pickOdd),
    .idxTop(idxTop), .idxMid(idxMid), .idxLow(idxLow),
    .srcA(srcA), .srcB(srcB), .acc(acc), .outValid(outValid), .result(result)
  );

  function automatic real bfReal(input logic [15:0] v);
    logic [10:0] ex = 11'(int'(v[14:7]) + 896);
    return $bitstoreal({v[15], ex, v[6:0], 45'b0});
  endfunction

  function automatic real fpReal(input logic [31:0] v);
    logic [10:0] ex = 11'(int'(v[30:23]) + 896);
    return $bitstoreal({v[31], ex, v[22:0], 29'b0});
  endfunction

  function automatic logic [31:0] refLane(input logic [15:0] a, input logic [15:0] b,
                                          input logic [31:0] c);
    logic aNan, bNan, cNan, aInf, bInf, cInf, aZ, bZ, cZ, ps, sgn, inc, guard, rest;
    real pv, cv, s, err;
    logic [63:0] db;
    int fe, r;
    aNan = a[14:7] == 8'hFF && a[6:0] != 0;
    bNan = b[14:7] == 8'hFF && b[6:0] != 0;
    cNan = c[30:23] == 8'hFF && c[22:0] != 0;
    aInf = a[14:7] == 8'hFF && !aNan;
    bInf = b[14:7] == 8'hFF && !bNan;
    cInf = c[30:23] == 8'hFF && !cNan;
    aZ = a[14:7] == 0;
    bZ = b[14:7] == 0;
    cZ = c[30:23] == 0;
    ps = a[15] ^ b[15];
    if (aNan || bNan || cNan) return 32'h7FC00000;
    if ((aInf || bInf) && (aZ || bZ)) return 32'h7FC00000;
    if ((aInf || bInf) && cInf && ps != c[31]) return 32'h7FC00000;
    if (aInf || bInf) return {ps, 8'hFF, 23'b0};
    if (cInf) return {c[31], 8'hFF, 23'b0};
    pv = (aZ || bZ) ? 0.0 : bfReal(a) * bfReal(b);
    cv = cZ ? 0.0 : fpReal(c);
    s = pv + cv;
    if (s == 0.0) return {ps & c[31], 31'b0};
    if ((pv < 0.0 ? -pv : pv) >= (cv < 0.0 ? -cv : cv)) err = cv - (s - pv);
    else err = pv - (s - cv);
    db = $realtobits(s);
    sgn = db[63];
    fe = int'(db[62:52]) - 896;
    if (fe >= 255) return {sgn, 8'hFF, 23'b0};
    if (fe < 0) return {sgn, 31'b0};
    guard = db[28];
    rest = |db[27:0];
    if (!guard) inc = 1'b0;
    else if (rest) inc = 1'b1;
    else if (err == 0.0) inc = db[29];
    else inc = ((err > 0.0) == (sgn == 1'b0));
    r = fe * (1 << 23) + int'(db[51:29]) + int'(inc);
    if ((r >> 23) >= 255) return {sgn, 8'hFF, 23'b0};
    if ((r >> 23) == 0) return {sgn, 31'b0};
    return {sgn, 8'(r >> 23), r[22:0]};
  endfunction

  function automatic logic [127:0] refVec(input logic [127:0] a, input logic [127:0] b,
                                          input logic [127:0] c, input logic odd,
                                          input logic [2:0] ix);
    logic [127:0] v;
    for (int e = 0; e < 4; e++)
      v[32*e +: 32] = refLane(a[16*(2*e + int'(odd)) +: 16], b[16*ix +: 16], c[32*e +: 32]);
    return v;
  endfunction

  // Behavioural model updated at every rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expValid <= 1'b0;
      expRes <= '0;
      expTag <= "R10";
    end else begin
      expValid <= inValid;
      expTag <= inValid ? curTag : "R1";
      if (inValid) expRes <= refVec(srcA, srcB, acc, pickOdd, {idxTop, idxMid, idxLow});
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (outValid !== expValid) begin
        errors++;
        $display("FAIL R1 outValid got %b exp %b", outValid, expValid);
      end
      for (int e = 0; e < 4; e++) begin
        checks++;
        if (result[32*e +: 32] !== expRes[32*e +: 32]) begin
          errors++;
          $display("FAIL %s lane %0d got %h exp %h", expTag, e,
                   result[32*e +: 32], expRes[32*e +: 32]);
        end
      end
    end
  end

  task automatic issue(input logic [31:0] tag, input logic [127:0] a, input logic [127:0] b,
                       input logic [127:0] c, input logic odd, input logic [2:0] ix);
    @(negedge clk);
    curTag = tag;
    srcA = a; srcB = b; acc = c;
    pickOdd = odd;
    {idxTop, idxMid, idxLow} = ix;
    inValid = 1'b1;
  endtask

  task automatic idle(input logic [127:0] junk);
    @(negedge clk);
    inValid = 1'b0;
    srcA = junk; srcB = ~junk; acc = junk ^ {4{32'h5A5A0F0F}};
    pickOdd = junk[0];
    {idxTop, idxMid, idxLow} = junk[3:1];
  endtask

  function automatic logic [15:0] rndBf(input int lo, input int hi);
    logic [7:0] ex = 8'(lo + int'($urandom_range(hi - lo)));
    return {1'($urandom), ex, 7'($urandom)};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] a, b, c;
    repeat (3) @(negedge clk);
    // R10: reset state
    checks += 2;
    if (outValid !== 1'b0) begin errors++; $display("FAIL R10 outValid got %b exp 0", outValid); end
    if (result !== '0) begin errors++; $display("FAIL R10 result got %h exp 0", result); end
    rstN = 1'b1;

    // R2, R3: distinct slots, every sel and index
    for (int s = 0; s < 2; s++) begin
      for (int ix = 0; ix < 8; ix++) begin
        for (int j = 0; j < 8; j++) begin
          a[16*j +: 16] = 16'h3F80 + 16'(j * 9 + 1);
          b[16*j +: 16] = 16'h4000 + 16'(j * 5 + 3);
        end
        for (int e = 0; e < 4; e++) c[32*e +: 32] = {1'b0, 8'(125 + e), 23'($urandom)};
        issue(s == 0 ? "R2" : "R3", a, b, c, 1'(s), 3'(ix));
      end
    end
    // R4: distinct accumulator lanes with a unit product
    issue("R4", {8{16'h3F80}}, {8{16'h3F80}},
          {32'h40400000, 32'h40000000, 32'hC0800000, 32'h3F000000}, 1'b0, 3'd2);

    // R1: idle cycles hold the result
    idle(rnd128());
    idle(rnd128());

    // R5: rounding corners
    issue("R5", {8{16'h3F80}}, {8{16'h3F80}},
          {32'h33800000, 32'h34400000, 32'hB3800000, 32'h33C00000}, 1'b1, 3'd7);
    issue("R5", {8{16'h3F81}}, {8{16'h3F81}},
          {32'hBF810000, 32'h4B800000, 32'h00800000, 32'hCB7FFFFF}, 1'b0, 3'd0);
    for (int n = 0; n < 300; n++) begin
      for (int j = 0; j < 8; j++) begin
        a[16*j +: 16] = rndBf(110, 140);
        b[16*j +: 16] = rndBf(110, 140);
      end
      for (int e = 0; e < 4; e++) c[32*e +: 32] = {1'($urandom), 8'(95 + $urandom_range(70)), 23'($urandom)};
      issue("R5", a, b, c, 1'($urandom), 3'($urandom));
    end
    for (int n = 0; n < 200; n++) issue("R5", rnd128(), rnd128(), rnd128(), 1'($urandom), 3'($urandom));

    // R6: NaN cases
    issue("R6", {8{16'h7FC1}}, {8{16'h3F80}}, {4{32'h3F800000}}, 1'b0, 3'd1);
    issue("R6", {8{16'h7F80}}, {8{16'h0000}}, {4{32'h3F800000}}, 1'b1, 3'd3);
    issue("R6", {8{16'h7F80}}, {8{16'h3F80}}, {4{32'hFF800000}}, 1'b0, 3'd4);
    issue("R6", {8{16'h3F80}}, {8{16'h3F80}}, {4{32'hFF800001}}, 1'b1, 3'd5);

    // R7: infinities and overflow
    issue("R7", {8{16'h7F7F}}, {8{16'h7F7F}}, {4{32'h3F800000}}, 1'b0, 3'd6);
    issue("R7", {8{16'hFF80}}, {8{16'h3F80}}, {4{32'hFF800000}}, 1'b1, 3'd0);
    issue("R7", {8{16'h3F80}}, {8{16'h3F80}}, {4{32'hFF800000}}, 1'b0, 3'd2);
    issue("R7", {8{16'h3F80}}, {8{16'h3F80}}, {4{32'h7F7FFFFF}}, 1'b0, 3'd1);

    // R8: subnormal inputs and tiny results
    issue("R8", {8{16'h0001}}, {8{16'h3F80}}, {4{32'h3F800000}}, 1'b0, 3'd3);
    issue("R8", {8{16'h3F80}}, {8{16'h3F80}}, {4{32'h00000001}}, 1'b1, 3'd4);
    issue("R8", {8{16'h0080}}, {8{16'h0080}}, {4{32'h00000000}}, 1'b0, 3'd5);
    issue("R8", {8{16'h8080}}, {8{16'h0080}}, {4{32'h80000000}}, 1'b1, 3'd6);
    issue("R8", {8{16'h0081}}, {8{16'h3F80}}, {4{32'h80800000}}, 1'b0, 3'd7);

    // R9: exact zero sums
    issue("R9", {8{16'h3F80}}, {8{16'h3F80}}, {4{32'hBF800000}}, 1'b0, 3'd0);
    issue("R9", {8{16'h8000}}, {8{16'h3F80}}, {4{32'h80000000}}, 1'b1, 3'd1);
    issue("R9", {8{16'h0000}}, {8{16'h3F80}}, {4{32'h80000000}}, 1'b0, 3'd2);
    issue("R9", {8{16'hBF80}}, {8{16'h3F80}}, {4{32'h3F800000}}, 1'b1, 3'd3);

    idle(rnd128());
    idle(rnd128());
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule